// File: doc/BRIEF.md
# Edge-Selectable External Capture Latch

This block takes a free-running counter value shared by several channels and, per channel, copies it into a capture register when an external digital trigger input changes level. Each channel has its own trigger input and two enable bits. One enable allows capture on a low-to-high transition of the trigger and the other allows capture on a high-to-low transition. The two can be used alone or together.

Each capture is single-shot. Once a polarity has fired it stays blocked until software drops its enable bit to 0 and raises it to 1 again. Short disturbances on the trigger line after a good capture therefore cannot overwrite the stored value. The trigger input is asynchronous. It passes through a synchronizer, and its synchronized level is reported back as a live status bit next to a valid flag and the captured count.

Top module: `ext_capture_latch`

## Requirements
- R1: `trig_level[c]` shows the level of `trig_raw[c]` after a two-flop synchronizer. A change that is present at clock edge k appears on `trig_level[c]` after edge k+1.
- R2: When the rising trigger of channel c is armed and `trig_level[c]` goes 0 to 1, the next clock edge loads `count_val` (as sampled at that edge) into the channel's slice of `cap_value` and sets `cap_valid[c]`. The whole path is three edges after the raw change.
- R3: The falling trigger behaves the same way on a 1-to-0 change of `trig_level[c]` while that trigger is armed.
- R4: After a polarity fires, further edges of that polarity leave the captured value unchanged until the polarity is re-armed. While no trigger fires, `cap_value` holds.
- R5: A trigger becomes armed at the clock edge that samples its enable bit at 1 after the previous edge sampled it at 0. After reset the previous sample counts as 0. Holding the enable at 1 never re-arms, and sampling it at 0 disarms the trigger.
- R6: A capture sets `cap_valid[c]`. The flag clears at the clock edge that samples both enable bits of the channel at 0, and it holds in every other case.
- R7: With both polarities enabled, the first qualifying edge disarms only the polarity that fired. A later edge of the other polarity captures again and overwrites the value.
- R8: All channels share `count_val` and act independently. Activity on one channel never changes another channel's outputs.
- R9: While `rst_n` is low, all outputs are 0 and both triggers of every channel are disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_raw | input | NUM_CH | Unsynchronized external trigger lines, one per channel |
| arm_rise | input | NUM_CH | Per-channel enable for capture on a rising trigger edge |
| arm_fall | input | NUM_CH | Per-channel enable for capture on a falling trigger edge |
| count_val | input | CNT_W | Shared counter value to capture |
| trig_level | output | NUM_CH | Synchronized live trigger level |
| cap_valid | output | NUM_CH | Capture-valid flag per channel |
| cap_value | output | NUM_CH*CNT_W | Captured counts; channel c occupies bits [c*CNT_W +: CNT_W] |

## Verification
The bench builds the block with NUM_CH=4, CNT_W=32 and SYNC_STAGES=2. Four channels make it possible to check that channels stay isolated while they share one count. A full 32-bit random count exercises every bit of the capture path. Two synchronizer stages fix the three-edge delay from raw trigger to captured value, so directed cases can check the exact count that was sampled.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Synchronized level went low to high between two samples
  function automatic logic rise_seen(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Synchronized level went high to low between two samples
  function automatic logic fall_seen(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  // Next armed state of one trigger polarity
  function automatic logic arm_update(input logic en, input logic en_prev,
                                      input logic armed, input logic fired);
    if (!en)           return 1'b0;
    else if (!en_prev) return 1'b1;
    else if (fired)    return 1'b0;
    else               return armed;
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hit,
  output logic armed,
  output logic fire
);
  logic en_q;
  logic armed_q;

  assign fire  = armed_q & enable & hit;
  assign armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= enable;
      armed_q <= cap_pkg::arm_update(enable, en_q, armed_q, fire);
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_raw,
  input  logic             arm_rise,
  input  logic             arm_fall,
  input  logic [CNT_W-1:0] count_val,
  output logic             trig_level,
  output logic             cap_valid,
  output logic [CNT_W-1:0] cap_value,
  output logic             armed_rise,
  output logic             armed_fall,
  output logic             fire_rise,
  output logic             fire_fall
);
  logic lvl;
  logic lvl_q;
  logic rise_hit;
  logic fall_hit;
  logic fire_any;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (trig_raw),
    .d_out (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise_hit = cap_pkg::rise_seen(lvl, lvl_q);
  assign fall_hit = cap_pkg::fall_seen(lvl, lvl_q);

  cap_trigger u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (arm_rise),
    .hit    (rise_hit),
    .armed  (armed_rise),
    .fire   (fire_rise)
  );

  cap_trigger u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (arm_fall),
    .hit    (fall_hit),
    .armed  (armed_fall),
    .fire   (fire_fall)
  );

  assign fire_any = fire_rise | fire_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_valid <= 1'b0;
    end else begin
      if (fire_any) cap_value <= count_val;
      if (fire_any)                   cap_valid <= 1'b1;
      else if (!arm_rise && !arm_fall) cap_valid <= 1'b0;
    end
  end

  assign trig_level = lvl;
endmodule

// File: rtl/ext_capture_latch.sv
module ext_capture_latch #(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       trig_raw,
  input  logic [NUM_CH-1:0]       arm_rise,
  input  logic [NUM_CH-1:0]       arm_fall,
  input  logic [CNT_W-1:0]        count_val,
  output logic [NUM_CH-1:0]       trig_level,
  output logic [NUM_CH-1:0]       cap_valid,
  output logic [NUM_CH*CNT_W-1:0] cap_value
);
  // Internal events brought out for the checker
  logic [NUM_CH-1:0] armed_rise_w;
  logic [NUM_CH-1:0] armed_fall_w;
  logic [NUM_CH-1:0] fire_rise_w;
  logic [NUM_CH-1:0] fire_fall_w;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cap_channel #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_raw   (trig_raw[c]),
        .arm_rise   (arm_rise[c]),
        .arm_fall   (arm_fall[c]),
        .count_val  (count_val),
        .trig_level (trig_level[c]),
        .cap_valid  (cap_valid[c]),
        .cap_value  (cap_value[c*CNT_W +: CNT_W]),
        .armed_rise (armed_rise_w[c]),
        .armed_fall (armed_fall_w[c]),
        .fire_rise  (fire_rise_w[c]),
        .fire_fall  (fire_fall_w[c])
      );
    end
  endgenerate
endmodule

// File: rtl/ext_capture_latch_chk.sv
module ext_capture_latch_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       arm_rise,
  input logic [NUM_CH-1:0]       arm_fall,
  input logic [CNT_W-1:0]        count_val,
  input logic [NUM_CH-1:0]       trig_level,
  input logic [NUM_CH-1:0]       cap_valid,
  input logic [NUM_CH*CNT_W-1:0] cap_value,
  input logic [NUM_CH-1:0]       armed_rise_w,
  input logic [NUM_CH-1:0]       armed_fall_w,
  input logic [NUM_CH-1:0]       fire_rise_w,
  input logic [NUM_CH-1:0]       fire_fall_w
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_RISE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rise_w[c] |=> cap_value[c*CNT_W +: CNT_W] == $past(count_val)); // R2
      AST_RISE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rise_w[c] |-> (arm_rise[c] && trig_level[c])); // R2
      AST_FALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_fall_w[c] |=> cap_value[c*CNT_W +: CNT_W] == $past(count_val)); // R3
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_rise_w[c] || fire_fall_w[c]) |=> $stable(cap_value[c*CNT_W +: CNT_W])); // R4
      AST_RISE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rise_w[c] |=> !armed_rise_w[c]); // R4
      AST_ARM_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_rise[c]) |=> armed_rise_w[c]); // R5
      AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_rise_w[c] || fire_fall_w[c]) |=> cap_valid[c]); // R6
      AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_rise[c] && !arm_fall[c]) |=> !cap_valid[c]); // R6
      AST_OTHER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_rise_w[c] && arm_fall[c] && armed_fall_w[c]) |=> armed_fall_w[c]); // R7
    end
  endgenerate
endmodule

bind ext_capture_latch ext_capture_latch_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm_rise     (arm_rise),
  .arm_fall     (arm_fall),
  .count_val    (count_val),
  .trig_level   (trig_level),
  .cap_valid    (cap_valid),
  .cap_value    (cap_value),
  .armed_rise_w (armed_rise_w),
  .armed_fall_w (armed_fall_w),
  .fire_rise_w  (fire_rise_w),
  .fire_fall_w  (fire_fall_w)
);

// File: tb/ext_capture_latch_tb.sv
module ext_capture_latch_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   trig_raw, arm_rise, arm_fall;
  logic [W-1:0]   count_val;
  logic [N-1:0]   trig_level, cap_valid;
  logic [N*W-1:0] cap_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ext_capture_latch #(.NUM_CH(N), .CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .arm_rise(arm_rise),
    .arm_fall(arm_fall), .count_val(count_val), .trig_level(trig_level),
    .cap_valid(cap_valid), .cap_value(cap_value)
  );

  // Reference model, stepped from the requirements
  function automatic logic m_arm(input logic en, input logic en_prev,
                                 input logic armed, input logic fired);
    if (en && !en_prev) return 1'b1;
    if (!en || fired)   return 1'b0;
    return armed;
  endfunction

  logic [N-1:0] m_s1, m_s2, m_s3, m_pr, m_pf, m_ar, m_af, m_val;
  logic [W-1:0] m_cap [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_pr <= '0; m_pf <= '0;
      m_ar <= '0; m_af <= '0; m_val <= '0;
      for (int c = 0; c < N; c++) m_cap[c] <= '0;
    end else begin
      for (int c = 0; c < N; c++) begin
        logic fr, ff;
        fr = m_ar[c] && arm_rise[c] && m_s2[c] && !m_s3[c];
        ff = m_af[c] && arm_fall[c] && !m_s2[c] && m_s3[c];
        m_ar[c] <= m_arm(arm_rise[c], m_pr[c], m_ar[c], fr);
        m_af[c] <= m_arm(arm_fall[c], m_pf[c], m_af[c], ff);
        if (fr || ff) begin
          m_cap[c] <= count_val;
          m_val[c] <= 1'b1;
        end else if (!arm_rise[c] && !arm_fall[c]) begin
          m_val[c] <= 1'b0;
        end
      end
      m_s1 <= trig_raw; m_s2 <= m_s1; m_s3 <= m_s2;
      m_pr <= arm_rise; m_pf <= arm_fall;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] capv(input int c);
    return cap_value[c*W +: W];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmp();
    for (int c = 0; c < N; c++) begin
      chk("R1 level vs model", W'(trig_level[c]), W'(m_s2[c]));
      chk("R6 valid vs model", W'(cap_valid[c]), W'(m_val[c]));
      chk("R4 value vs model", capv(c), m_cap[c]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; trig_raw = '0; arm_rise = '0; arm_fall = '0; count_val = '0;
    tick(3);
    chk("R9 reset valid", W'(cap_valid), '0);
    chk("R9 reset level", W'(trig_level), '0);
    chk("R9 reset value ch0", capv(0), '0);
    rst_n = 1'b1;
    tick(1);

    // R2: armed rising capture, count sampled three edges after raw change
    arm_rise[0] = 1'b1;
    tick(1);
    trig_raw[0] = 1'b1; count_val = 32'd100;
    tick(1);
    chk("R1 level not yet", W'(trig_level[0]), 32'd0);
    count_val = 32'd101;
    tick(1);
    chk("R1 level after two edges", W'(trig_level[0]), 32'd1);
    chk("R2 valid not yet", W'(cap_valid[0]), 32'd0);
    count_val = 32'd102;
    tick(1);
    chk("R2 rise value", capv(0), 32'd102);
    chk("R2 rise valid", W'(cap_valid[0]), 32'd1);

    // R4: second rising edge without re-arm is ignored
    trig_raw[0] = 1'b0; tick(3);
    trig_raw[0] = 1'b1; count_val = 32'd200; tick(4);
    chk("R4 one-shot hold", capv(0), 32'd102);

    // R6: both enables low clears valid
    arm_rise[0] = 1'b0; tick(1);
    chk("R6 valid cleared", W'(cap_valid[0]), 32'd0);
    chk("R6 value kept", capv(0), 32'd102);

    // R5: re-arm by 0 -> 1
    arm_rise[0] = 1'b1; tick(1);
    trig_raw[0] = 1'b0; tick(3);
    trig_raw[0] = 1'b1; count_val = 32'd300; tick(3);
    chk("R5 re-armed capture", capv(0), 32'd300);

    // R3: falling capture
    arm_fall[0] = 1'b1; tick(1);
    trig_raw[0] = 1'b0; count_val = 32'd400; tick(3);
    chk("R3 fall value", capv(0), 32'd400);
    chk("R3 fall valid", W'(cap_valid[0]), 32'd1);

    // R7: both enabled, each polarity fires once
    arm_rise[0] = 1'b0; arm_fall[0] = 1'b0; tick(1);
    arm_rise[0] = 1'b1; arm_fall[0] = 1'b1; tick(1);
    trig_raw[0] = 1'b1; count_val = 32'd500; tick(3);
    chk("R7 first rise", capv(0), 32'd500);
    trig_raw[0] = 1'b0; count_val = 32'd600; tick(3);
    chk("R7 other polarity still armed", capv(0), 32'd600);
    trig_raw[0] = 1'b1; count_val = 32'd700; tick(3);
    chk("R7 both spent", capv(0), 32'd600);

    // R8: untouched channels unaffected
    for (int c = 1; c < N; c++) begin
      chk("R8 other channel value", capv(c), '0);
      chk("R8 other channel valid", W'(cap_valid[c]), '0);
    end

    // R5: enable held high through reset arms on first edge after release
    rst_n = 1'b0; arm_rise = '0; arm_fall = '0; trig_raw = '0;
    arm_rise[2] = 1'b1;
    tick(2);
    rst_n = 1'b1; tick(1);
    trig_raw[2] = 1'b1; count_val = 32'hDEAD_BEEF; tick(3);
    chk("R5 armed after reset", capv(2), 32'hDEAD_BEEF);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      model_cmp();
      for (int c = 0; c < N; c++) begin
        if (($urandom % 4) == 0)  trig_raw[c] = ~trig_raw[c];
        if (($urandom % 16) == 0) arm_rise[c] = ~arm_rise[c];
        if (($urandom % 16) == 0) arm_fall[c] = ~arm_fall[c];
      end
      count_val = $urandom;
      tick(1);
    end
    model_cmp();
    finish_run();
  end
endmodule